// File: doc/BRIEF.md
# Scaled FP8 Downconverter with Saturation

This block turns one half-precision value into one 8-bit floating-point byte. A 3-bit code picks the destination encoding. Code 0 is the 5-bit-exponent, 2-bit-mantissa form, which has infinities. Code 1 is the 4-bit-exponent, 3-bit-mantissa form, which has no infinity and only one NaN magnitude. Before rounding, a signed power-of-two prescale is added to the operand's exponent. This lets a tensor kernel fold a per-block scale factor into the narrowing step.

Rounding is always to nearest, with ties to even. A saturation input picks how a result that is too large is delivered. It comes out either as the largest finite magnitude or as the format's overflow pattern (infinity, or NaN where no infinity exists). Each result carries four exception flags: overflow, underflow, inexact and invalid. An unsupported format code gives a fixed all-ones byte, so a later stage can spot it.

With the default settings, the result and its flags appear one clock after a valid input. Inputs are accepted on every cycle.

Top module: `fp8_scaled_downcvt`

## Requirements
- R1: While reset is held low, and until the first valid input after it, out_valid, out_byte and all four flags are 0.
- R2: A valid input gives a valid output exactly one clock later. A cycle without in_valid gives out_valid low one clock later. Back-to-back inputs give back-to-back results.
- R3: Code 0 gives byte {sign[7], exp[6:2] with bias 15, man[1:0]}. Code 1 gives {sign[7], exp[6:3] with bias 7, man[2:0]}. An exact in-range value raises no flag (for example, 1.0 gives 0x3C for code 0 and 0x38 for code 1).
- R4: in_scale is a two's-complement integer added to the unbiased exponent before rounding, so the result equals input × 2^scale. This also holds for subnormal half-precision inputs.
- R5: Rounding is to nearest with ties to even. out_inx is set when any nonzero bits are discarded.
- R6: Overflow is judged after rounding. Code 0 overflows above 0x7B (57344). Code 1 overflows above 0x7E (448). With in_sat=0, an overflow gives sign|0x7C for code 0 and sign|0x7F for code 1, with out_ovf and out_inx set.
- R7: With in_sat=1, an overflow gives the largest finite magnitude with the input's sign: sign|0x7B for code 0 and sign|0x7E for code 1. out_ovf and out_inx are set.
- R8: A result below the smallest normal magnitude rounds into a subnormal or to signed zero, and may round up to the smallest normal. out_unf is set when the scaled value was below the smallest normal before rounding and the result is inexact. An exact tiny result raises no flag.
- R9: A NaN input gives sign|0x7E for code 0 and sign|0x7F for code 1. out_inv is set only for a signalling NaN, meaning half-precision mantissa bit 9 = 0.
- R10: An infinite input gives sign|0x7C for code 0 and raises no flag. For code 1 it gives sign|0x7E when in_sat=1 and sign|0x7F when in_sat=0, also raising no flag.
- R11: A format code of 2 or more gives out_byte=0xFF with only out_inv set, whatever the operand, scale or saturation bit.
- R12: A zero input gives a zero of the same sign with no flags, whatever the scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand is valid this cycle |
| in_half | input | 16 | Half-precision operand |
| in_fmt | input | FMT_W (3) | Destination format code |
| in_scale | input | SCALE_W (8) | Signed exponent prescale |
| in_sat | input | 1 | 1: saturate on overflow; 0: overflow pattern |
| out_valid | output | 1 | Result is valid |
| out_byte | output | 8 | FP8 result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |
| out_inv | output | 1 | Invalid-operation flag |

## Verification
The properties check four things on every cycle: that the output valid tracks the input valid with a one-cycle lag, that an unsupported code always produces 0xFF with invalid alone, that overflow and underflow never appear without inexact, and that saturation never lets the overflow pattern out of a rounding unit. The bench scenarios are the only way to show the numerical content. That covers exact byte values under different scales, tie-to-even decisions, the overflow boundary after rounding carries, tiny values rounding up to the smallest normal, and the handling of NaN, infinity and signed zero in each format.

// File: rtl/fp8cv_pkg.sv
package fp8cv_pkg;
   localparam int HALF_W    = 16;
   localparam int HALF_MB   = 10;
   localparam int HALF_BIAS = 15;
   localparam int SIG_W     = HALF_MB + 1;
   localparam int NUM_FMT   = 2;

   typedef enum logic [2:0] {
      CL_ZERO, CL_FIN, CL_INF, CL_QNAN, CL_SNAN
   } in_class_e;

   typedef struct packed {
      logic ovf;
      logic unf;
      logic inx;
      logic inv;
   } fp8_flags_t;

   // format index 0: 5-bit exponent with infinities; index 1: 4-bit, no infinity
   function automatic int fmt_ebits(input int f);
      return (f == 0) ? 5 : 4;
   endfunction

   function automatic int fmt_mbits(input int f);
      return (f == 0) ? 2 : 3;
   endfunction

   function automatic bit fmt_has_inf(input int f);
      return (f == 0);
   endfunction

   localparam logic [6:0] NAN_MAG_E5  = 7'h7E;
   localparam logic [6:0] INF_MAG_E5  = 7'h7C;
   localparam logic [6:0] NAN_MAG_E4  = 7'h7F;
   localparam logic [6:0] MAXF_MAG_E4 = 7'h7E;
endpackage

// File: rtl/fp16_classify.sv
module fp16_classify
   import fp8cv_pkg::*;
#(
   parameter int SCALE_W = 8
) (
   input  logic                      [HALF_W-1:0]  half_i,
   input  logic signed               [SCALE_W-1:0] scale_i,
   output logic                                    sign_o,
   output in_class_e                               cls_o,
   output logic signed               [SCALE_W+1:0] exp_o,
   output logic                      [SIG_W-1:0]   sig_o
);
   localparam int XW = SCALE_W + 2;

   logic [4:0]       fld_e;
   logic [9:0]       fld_m;
   logic [SIG_W-1:0] sig_raw;
   int               lead;
   int               ev;

   always_comb begin
      fld_e   = half_i[14:10];
      fld_m   = half_i[9:0];
      sign_o  = half_i[15];
      sig_raw = {(fld_e != 5'd0), fld_m};
      lead    = 0;
      for (int i = 0; i < SIG_W; i++)
         if (sig_raw[i]) lead = i;
      // normalise so the leading one sits at the top of the significand
      sig_o = sig_raw << (HALF_MB - lead);
      ev    = (fld_e != 5'd0) ? int'(fld_e) - HALF_BIAS : lead - (HALF_BIAS + HALF_MB - 1);
      ev    = ev + int'(scale_i);
      exp_o = XW'(ev);
      if (fld_e == 5'h1F)
         cls_o = (fld_m == 10'd0) ? CL_INF : (fld_m[9] ? CL_QNAN : CL_SNAN);
      else if (fld_e == 5'd0 && fld_m == 10'd0)
         cls_o = CL_ZERO;
      else
         cls_o = CL_FIN;
   end
endmodule

// File: rtl/fp8_round_pack.sv
module fp8_round_pack
   import fp8cv_pkg::*;
#(
   parameter int EB      = 5,
   parameter int MB      = 2,
   parameter bit HAS_INF = 1'b1,
   parameter int XW      = 10
) (
   input  logic                 sign_i,
   input  logic signed [XW-1:0] exp_i,
   input  logic [SIG_W-1:0]     sig_i,
   input  logic                 sat_i,
   output logic [7:0]           res_o,
   output logic                 ovf_o,
   output logic                 unf_o,
   output logic                 inx_o
);
   localparam int BIAS     = 2 ** (EB - 1) - 1;
   localparam int EMIN     = 1 - BIAS;
   localparam int EMAXF    = HAS_INF ? 2 ** EB - 2 : 2 ** EB - 1;
   localparam int MAXF_MAN = HAS_INF ? 2 ** MB - 1 : 2 ** MB - 2;
   localparam int KW       = MB + 1;
   localparam int RW       = MB + 2;
   localparam int WW       = SIG_W + 16;
   localparam int SH_CAP   = 16;
   localparam logic [6:0] MAX_MAG = 7'((EMAXF << MB) | MAXF_MAN);
   localparam logic [6:0] OVF_MAG = HAS_INF ? 7'((2 ** EB - 1) << MB) : 7'h7F;

   if (EB + MB != 7) begin : g_bad_split
      $error("fp8_round_pack: EB+MB must be 7");
   end

   int            e_unb, e_cl, sh, bexp;
   logic [WW-1:0] shifted;
   logic [KW-1:0] kept;
   logic [RW-1:0] rk;
   logic [MB-1:0] man;
   logic          rbit, sticky, inc, tiny, carry, norm, ovf;

   always_comb begin
      e_unb   = int'(exp_i);
      tiny    = (e_unb < EMIN);
      e_cl    = tiny ? EMIN : e_unb;
      sh      = (SIG_W - 1 - MB) + (e_cl - e_unb);
      if (sh > SH_CAP) sh = SH_CAP;
      shifted = {sig_i, 16'b0} >> sh;
      kept    = KW'(shifted >> 16);
      rbit    = shifted[15];
      sticky  = |shifted[14:0];
      inc     = rbit & (sticky | kept[0]);
      rk      = RW'(kept) + RW'(inc);
      carry   = rk[MB+1];
      norm    = rk[MB] | carry;
      bexp    = norm ? e_cl + BIAS + (carry ? 1 : 0) : 0;
      man     = carry ? '0 : rk[MB-1:0];
      ovf     = (bexp > EMAXF) || (bexp == EMAXF && int'(man) > MAXF_MAN);
      if (ovf)
         res_o = {sign_i, sat_i ? MAX_MAG : OVF_MAG};
      else
         res_o = {sign_i, EB'(bexp), man};
      ovf_o = ovf;
      inx_o = ovf | rbit | sticky;
      unf_o = tiny & (rbit | sticky);
   end

   // R7
   always_comb begin
      if (sat_i && !$isunknown(res_o))
         sat_no_ovfpat_chk: assert (res_o[6:0] != OVF_MAG);
   end
endmodule

// File: rtl/fp8_scaled_downcvt.sv
module fp8_scaled_downcvt
   import fp8cv_pkg::*;
#(
   parameter int SCALE_W = 8,
   parameter int FMT_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [15:0]               in_half,
   input  logic [FMT_W-1:0]          in_fmt,
   input  logic signed [SCALE_W-1:0] in_scale,
   input  logic                      in_sat,
   output logic                      out_valid,
   output logic [7:0]                out_byte,
   output logic                      out_ovf,
   output logic                      out_unf,
   output logic                      out_inx,
   output logic                      out_inv
);
   localparam int XW = SCALE_W + 2;

   if (SCALE_W < 2 || SCALE_W > 8) begin : g_bad_scale
      $error("fp8_scaled_downcvt: SCALE_W must be 2..8");
   end
   if (FMT_W < 2) begin : g_bad_fmt
      $error("fp8_scaled_downcvt: FMT_W must be at least 2");
   end

   logic                 sgn;
   in_class_e            cls;
   logic signed [XW-1:0] sexp;
   logic [SIG_W-1:0]     nsig;

   fp16_classify #(.SCALE_W(SCALE_W)) u_cls (
      .half_i (in_half),
      .scale_i(in_scale),
      .sign_o (sgn),
      .cls_o  (cls),
      .exp_o  (sexp),
      .sig_o  (nsig)
   );

   logic [7:0]         pk_res [NUM_FMT];
   logic [NUM_FMT-1:0] pk_ovf, pk_unf, pk_inx;

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      fp8_round_pack #(
         .EB     (fmt_ebits(g)),
         .MB     (fmt_mbits(g)),
         .HAS_INF(fmt_has_inf(g)),
         .XW     (XW)
      ) u_pack (
         .sign_i(sgn),
         .exp_i (sexp),
         .sig_i (nsig),
         .sat_i (in_sat),
         .res_o (pk_res[g]),
         .ovf_o (pk_ovf[g]),
         .unf_o (pk_unf[g]),
         .inx_o (pk_inx[g])
      );
   end

   logic       supported, sel;
   logic [7:0] nxt_byte;
   fp8_flags_t nxt_fl;

   always_comb begin
      supported = (in_fmt < FMT_W'(NUM_FMT));
      sel       = in_fmt[0];
      nxt_byte  = 8'h00;
      nxt_fl    = '0;
      if (!supported) begin
         nxt_byte   = 8'hFF;
         nxt_fl.inv = 1'b1;
      end else begin
         unique case (cls)
            CL_ZERO: nxt_byte = {sgn, 7'h00};
            CL_INF:  nxt_byte = !sel ? {sgn, INF_MAG_E5}
                                     : {sgn, in_sat ? MAXF_MAG_E4 : NAN_MAG_E4};
            CL_QNAN, CL_SNAN: begin
               nxt_byte   = {sgn, !sel ? NAN_MAG_E5 : NAN_MAG_E4};
               nxt_fl.inv = (cls == CL_SNAN);
            end
            default: begin
               nxt_byte   = pk_res[sel];
               nxt_fl.ovf = pk_ovf[sel];
               nxt_fl.unf = pk_unf[sel];
               nxt_fl.inx = pk_inx[sel];
            end
         endcase
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= 8'h00;
            {out_ovf, out_unf, out_inx, out_inv} <= 4'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_byte <= nxt_byte;
               {out_ovf, out_unf, out_inx, out_inv} <= nxt_fl;
            end
         end
      end

      // R2
      valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R2
      idle_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R11
      bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_fmt >= FMT_W'(NUM_FMT)) |=>
         (out_byte == 8'hFF && out_inv && !out_ovf && !out_unf && !out_inx));
      // R6
      ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_ovf) |-> (out_inx && !out_unf));
      // R8
      unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_unf) |-> out_inx);
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_byte  = nxt_byte;
      assign {out_ovf, out_unf, out_inx, out_inv} = nxt_fl;
   end
endmodule

// File: tb/sim_fp8_scaled_downcvt.sv
module sim_fp8_scaled_downcvt;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [15:0]       in_half = 16'h0;
   logic [2:0]        in_fmt = 3'd0;
   logic signed [7:0] in_scale = 8'sd0;
   logic              in_sat = 1'b0;
   logic              out_valid;
   logic [7:0]        out_byte;
   logic              out_ovf, out_unf, out_inx, out_inv;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #4 clk = ~clk;

   fp8_scaled_downcvt u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
      .in_fmt(in_fmt), .in_scale(in_scale), .in_sat(in_sat),
      .out_valid(out_valid), .out_byte(out_byte), .out_ovf(out_ovf),
      .out_unf(out_unf), .out_inx(out_inx), .out_inv(out_inv)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", what, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] h, input logic [2:0] f,
                        input logic signed [7:0] sc, input logic st);
      in_valid = 1'b1; in_half = h; in_fmt = f; in_scale = sc; in_sat = st;
   endtask

   // one conversion; flags expected as {ovf,unf,inx,inv}
   task automatic cvt(input logic [15:0] h, input logic [2:0] f, input logic signed [7:0] sc,
                      input logic st, input logic [7:0] eb, input logic [3:0] ef, input string rq);
      drive(h, f, sc, st);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk({15'd0, out_valid}, 16'd1, {rq, " valid"});
      chk({8'd0, out_byte}, {8'd0, eb}, {rq, " byte"});
      chk({12'd0, out_ovf, out_unf, out_inx, out_inv}, {12'd0, ef}, {rq, " flags"});
   endtask

   task automatic t_r1_reset;
      chk({8'd0, out_byte}, 16'd0, "R1 byte in reset");
      chk({11'd0, out_valid, out_ovf, out_unf, out_inx, out_inv}, 16'd0, "R1 valid/flags in reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk({11'd0, out_valid, out_ovf, out_unf, out_inx, out_inv}, 16'd0, "R1 after release");
   endtask

   task automatic t_r2_stream;
      drive(16'h3C00, 3'd0, 8'sd0, 1'b0);
      @(posedge clk); @(negedge clk);
      drive(16'h3C00, 3'd1, 8'sd0, 1'b0);
      chk({8'd0, out_byte}, 16'h3C, "R2 first of pair");
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk({15'd0, out_valid}, 16'd1, "R2 second valid");
      chk({8'd0, out_byte}, 16'h38, "R2 second of pair");
      @(posedge clk); @(negedge clk);
      chk({15'd0, out_valid}, 16'd0, "R2 idle gap");
   endtask

   task automatic t_r3_formats;
      cvt(16'h3C00, 3'd0, 8'sd0, 1'b0, 8'h3C, 4'b0000, "R3 one e5");
      cvt(16'h3C00, 3'd1, 8'sd0, 1'b0, 8'h38, 4'b0000, "R3 one e4");
      cvt(16'hC000, 3'd1, 8'sd0, 1'b0, 8'hC0, 4'b0000, "R3 minus two e4");
   endtask

   task automatic t_r4_scale;
      cvt(16'h3C00, 3'd1, 8'sd2,  1'b0, 8'h48, 4'b0000, "R4 scale +2");
      cvt(16'h3C00, 3'd0, -8'sd3, 1'b0, 8'h30, 4'b0000, "R4 scale -3");
      cvt(16'h0001, 3'd0, 8'sd20, 1'b0, 8'h2C, 4'b0000, "R4 subnormal in");
   endtask

   task automatic t_r5_round;
      cvt(16'h3C80, 3'd0, 8'sd0, 1'b0, 8'h3C, 4'b0010, "R5 tie to even down");
      cvt(16'h3D80, 3'd0, 8'sd0, 1'b0, 8'h3E, 4'b0010, "R5 tie to even up");
      cvt(16'h3C80, 3'd1, 8'sd0, 1'b0, 8'h39, 4'b0000, "R5 exact e4");
   endtask

   task automatic t_r6_overflow;
      cvt(16'h5F80, 3'd1, 8'sd0,  1'b0, 8'h7F, 4'b1010, "R6 e4 overflow");
      cvt(16'h7BFF, 3'd0, 8'sd0,  1'b0, 8'h7C, 4'b1010, "R6 e5 carry overflow");
      cvt(16'hBC00, 3'd0, 8'sd20, 1'b0, 8'hFC, 4'b1010, "R6 e5 negative");
      cvt(16'h5F00, 3'd1, 8'sd0,  1'b0, 8'h7E, 4'b0000, "R6 e4 max finite");
      cvt(16'h7B00, 3'd0, 8'sd0,  1'b0, 8'h7B, 4'b0000, "R6 e5 max finite");
   endtask

   task automatic t_r7_saturate;
      cvt(16'h5F80, 3'd1, 8'sd0,  1'b1, 8'h7E, 4'b1010, "R7 e4 saturate");
      cvt(16'h7BFF, 3'd0, 8'sd0,  1'b1, 8'h7B, 4'b1010, "R7 e5 saturate");
      cvt(16'hBC00, 3'd0, 8'sd20, 1'b1, 8'hFB, 4'b1010, "R7 e5 negative saturate");
   endtask

   task automatic t_r8_tiny;
      cvt(16'h3C00, 3'd1, -8'sd8,  1'b0, 8'h02, 4'b0000, "R8 exact subnormal");
      cvt(16'h3E00, 3'd1, -8'sd10, 1'b0, 8'h01, 4'b0110, "R8 rounded subnormal");
      cvt(16'h3C00, 3'd1, -8'sd20, 1'b0, 8'h00, 4'b0110, "R8 flush to zero");
      cvt(16'hBC00, 3'd0, -8'sd20, 1'b0, 8'h80, 4'b0110, "R8 negative zero");
      cvt(16'h3FFF, 3'd1, -8'sd7,  1'b0, 8'h08, 4'b0110, "R8 round to min normal");
   endtask

   task automatic t_r9_nan;
      cvt(16'h7E00, 3'd0, 8'sd0, 1'b0, 8'h7E, 4'b0000, "R9 qnan e5");
      cvt(16'h7E00, 3'd1, 8'sd0, 1'b1, 8'h7F, 4'b0000, "R9 qnan e4");
      cvt(16'h7C01, 3'd1, 8'sd0, 1'b0, 8'h7F, 4'b0001, "R9 snan");
      cvt(16'hFE00, 3'd0, 8'sd5, 1'b0, 8'hFE, 4'b0000, "R9 negative nan");
   endtask

   task automatic t_r10_inf;
      cvt(16'h7C00, 3'd0, 8'sd0, 1'b1, 8'h7C, 4'b0000, "R10 inf e5");
      cvt(16'hFC00, 3'd1, 8'sd0, 1'b1, 8'hFE, 4'b0000, "R10 inf e4 sat");
      cvt(16'h7C00, 3'd1, 8'sd0, 1'b0, 8'h7F, 4'b0000, "R10 inf e4 nonsat");
   endtask

   task automatic t_r11_unsupported;
      cvt(16'h3C00, 3'd2, 8'sd0,  1'b0, 8'hFF, 4'b0001, "R11 code 2");
      cvt(16'h7E00, 3'd7, 8'sd0,  1'b1, 8'hFF, 4'b0001, "R11 code 7 nan");
      cvt(16'h7BFF, 3'd3, 8'sd60, 1'b0, 8'hFF, 4'b0001, "R11 code 3 huge");
   endtask

   task automatic t_r12_zero;
      cvt(16'h8000, 3'd1, 8'sd50,    1'b0, 8'h80, 4'b0000, "R12 negative zero");
      cvt(16'h0000, 3'd0, -8'sd100,  1'b1, 8'h00, 4'b0000, "R12 positive zero");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_r1_reset;
      t_r2_stream;
      t_r3_formats;
      t_r4_scale;
      t_r5_round;
      t_r6_overflow;
      t_r7_saturate;
      t_r8_tiny;
      t_r9_nan;
      t_r10_inf;
      t_r11_unsupported;
      t_r12_zero;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule